// File: doc/BRIEF.md
# YCbCr 4:2:2 Video Input Unpacker

This block is the front end of a video capture path. It takes 4:2:2 YCbCr video on a luma bus and a chroma bus, both 8 bits wide. For every two pixels it delivers one registered group of Y0, Y1, Cb and Cr, together with a one-cycle valid strobe and horizontal sync, vertical sync, field and active-video flags. All of it runs on the input pixel clock.

The block accepts three input formats.
- **Wide:** 16 bits per sample, with luma and chroma on separate buses and external sync.
- **Narrow:** 8-bit multiplexed on the luma bus, with external sync.
- **Embedded:** 8-bit multiplexed, with timing taken from reference codes carried in the byte stream.

The format is requested either by two mode pins or by two register bits, and a select bit chooses which of the two pairs is in control. A requested change waits for the next line start. A line start is a rising edge of the external horizontal sync or a detected start-of-active-video code. The line start that applies the change is already handled in the new format.

Top module: `ycc_unpack`

## Requirements
- R1: The requested format comes from `reg_embed`/`reg_narrow` when `use_regs` is 1, and from `pin_embed`/`pin_narrow` otherwise. An embed bit of 1 selects embedded mode whatever the narrow bit is. Otherwise a narrow bit of 1 selects narrow mode and 0 selects wide mode.
- R2: The applied format changes only in a cycle that holds a line start. That cycle already uses the requested format.
- R3: In wide mode, the sample that coincides with the first high sample of `ext_hsync`, and every second sample after it, is slot 0.
  - Slot 0 carries Y0 on `luma_in` and Cb on `chroma_in`.
  - The next sample carries Y1 and Cr.
  - The pair appears on the outputs with `pair_valid_o` high one clock after the second sample.
  - Between pairs the pair outputs hold their values.
- R4: In narrow mode, bytes on `luma_in` repeat in the order Cb, Y0, Cr, Y1. The order restarts at Cb on the byte that coincides with the first high sample of `ext_hsync`, even in the middle of a group. One pair is produced one clock after each Y1 byte.
- R5: In both 8-bit modes `chroma_in` has no effect on any output.
- R6: A code is the byte sequence FF, 00, 00 followed by a status byte on `luma_in`. In the status byte, bit 4 = 0 marks start of active video (SAV) and bit 4 = 1 marks end of active video (EAV).
  - In embedded mode, SAV opens the line, and the byte after it is Cb.
  - EAV closes the line.
  - A status byte never completes a pair, and no pairs are produced while the line is closed.
- R7: In embedded mode, `hsync_o`, `vsync_o` and `field_o` hold status bits 4, 5 and 6 of the last code. No pairs are produced while bit 5 is 1.
- R8: In wide and narrow modes, `hsync_o` and `vsync_o` follow `ext_hsync` and `ext_vsync` one clock later, and `field_o` is 0. No pair is produced while `ext_vsync` is high. In embedded mode the external sync inputs have no effect on the outputs.
- R9: During reset and after it, every output is 0 and the applied format is wide. No pair is produced before the first line start.
- R10: `active_o` is 1 one clock after a cycle in which the line is open and not vertically blanked, and it is 1 whenever `pair_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| use_regs | input | 1 | 1: register bits select the format; 0: mode pins select it |
| pin_narrow | input | 1 | Mode pin, 1 = 8-bit input |
| pin_embed | input | 1 | Mode pin, 1 = embedded-code input |
| reg_narrow | input | 1 | Register bit, 1 = 8-bit input |
| reg_embed | input | 1 | Register bit, 1 = embedded-code input |
| ext_hsync | input | 1 | External horizontal sync, rising edge starts a line |
| ext_vsync | input | 1 | External vertical sync, high = vertical blanking |
| luma_in | input | 8 | Luma bus, or multiplexed YCbCr bytes in 8-bit modes |
| chroma_in | input | 8 | Chroma bus in wide mode (Cb, then Cr) |
| y0_o | output | 8 | First luma sample of the pair |
| y1_o | output | 8 | Second luma sample of the pair |
| cb_o | output | 8 | Blue-difference sample of the pair |
| cr_o | output | 8 | Red-difference sample of the pair |
| pair_valid_o | output | 1 | One-cycle strobe: a new pair is on the outputs |
| hsync_o | output | 1 | Horizontal sync / blanking flag |
| vsync_o | output | 1 | Vertical sync / blanking flag |
| field_o | output | 1 | Field flag (embedded mode only) |
| active_o | output | 1 | Line open and not vertically blanked |

## Verification
The properties assume that in embedded mode the code preamble begins on a Cb slot, so that a status byte falls where a Y1 would fall. They also assume that active picture bytes never form the FF, 00, 00 pattern, because a stray match would be taken as a code. The stimulus uses only data bytes below FF, sends every code aligned to a four-byte group, and applies format requests before the line start that is meant to take them. It also moves `ext_hsync` only between whole samples, so each rising edge is seen on exactly one clock.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

  // Applied input format
  typedef enum logic [1:0] {
    FMT_WIDE16 = 2'd0,
    FMT_BYTE8  = 2'd1,
    FMT_EMBED  = 2'd2
  } fmt_e;

  // Status byte bit positions of an embedded timing code
  localparam int ST_EOA_BIT = 4;
  localparam int ST_VB_BIT  = 5;
  localparam int ST_FLD_BIT = 6;

  // Embed request wins over the width request
  function automatic fmt_e pick_fmt(input logic embed, input logic narrow);
    if (embed)       return FMT_EMBED;
    else if (narrow) return FMT_BYTE8;
    else             return FMT_WIDE16;
  endfunction

endpackage

// File: rtl/ycc_fmt_ctrl.sv
module ycc_fmt_ctrl
  import ycc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic use_regs,
  input  logic pin_embed,
  input  logic pin_narrow,
  input  logic reg_embed,
  input  logic reg_narrow,
  input  logic line_start,
  output fmt_e fmt_q,
  output fmt_e eff_fmt,
  output logic fmt_switch
);

  fmt_e req_fmt;
  fmt_e fmt_d;

  always_comb begin
    req_fmt = use_regs ? pick_fmt(reg_embed, reg_narrow)
                       : pick_fmt(pin_embed, pin_narrow);
    fmt_d   = fmt_q;
    if (line_start) fmt_d = req_fmt;
  end

  // The line-start cycle already runs in the requested format
  assign eff_fmt    = fmt_d;
  assign fmt_switch = line_start && (req_fmt != fmt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fmt_q <= FMT_WIDE16;
    else if (line_start) fmt_q <= fmt_d;
  end

endmodule

// File: rtl/ycc_code_detect.sv
module ycc_code_detect #(
  parameter int DATA_W  = 8,
  parameter int PRE_LEN = 3,
  parameter int EOA_BIT = 4,
  parameter int VB_BIT  = 5,
  parameter int FLD_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic              code_hit,
  output logic              sav,
  output logic              eav,
  output logic              st_vblank,
  output logic              st_field
);

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic [DATA_W-1:0] hist_q [PRE_LEN];
  logic [PRE_LEN-1:0] stage_ok;

  // hist_q[0] is the previous byte, hist_q[PRE_LEN-1] the oldest
  for (genvar g = 0; g < PRE_LEN; g++) begin : g_hist
    logic [DATA_W-1:0] stage_d;
    if (g == 0) begin : g_head
      assign stage_d = din;
    end else begin : g_tail
      assign stage_d = hist_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[g] <= '0;
      else        hist_q[g] <= stage_d;
    end

    if (g == PRE_LEN-1) begin : g_lead
      assign stage_ok[g] = (hist_q[g] == ALL_ONES);
    end else begin : g_zero
      assign stage_ok[g] = (hist_q[g] == '0);
    end
  end

  assign code_hit  = &stage_ok;
  assign sav       = code_hit && !din[EOA_BIT];
  assign eav       = code_hit &&  din[EOA_BIT];
  assign st_vblank = din[VB_BIT];
  assign st_field  = din[FLD_BIT];

endmodule

// File: rtl/ycc_pair_asm.sv
module ycc_pair_asm
  import ycc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GROUP8  = 4,
  parameter int GROUP16 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              eff_fmt,
  input  logic              fmt_switch,
  input  logic              hs_rise,
  input  logic              ext_hsync,
  input  logic              ext_vsync,
  input  logic [DATA_W-1:0] luma,
  input  logic [DATA_W-1:0] chroma,
  input  logic              code_hit,
  input  logic              sav,
  input  logic              eav,
  input  logic              st_vblank,
  input  logic              st_field,
  output logic [DATA_W-1:0] y0_o,
  output logic [DATA_W-1:0] y1_o,
  output logic [DATA_W-1:0] cb_o,
  output logic [DATA_W-1:0] cr_o,
  output logic              pair_valid_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              field_o,
  output logic              active_o
);

  localparam int PH_W = $clog2(GROUP8);
  localparam logic [PH_W-1:0] LAST8  = PH_W'(GROUP8 - 1);
  localparam logic [PH_W-1:0] LAST16 = PH_W'(GROUP16 - 1);
  localparam logic [PH_W-1:0] SLOT_CB = PH_W'(0);
  localparam logic [PH_W-1:0] SLOT_Y0 = PH_W'(1);
  localparam logic [PH_W-1:0] SLOT_CR = PH_W'(2);

  // State
  logic [PH_W-1:0]   phase_q, phase_d;
  logic              open_q;
  logic              h_q, h_d, v_q, v_d, f_q, f_d;
  logic [DATA_W-1:0] hy0_q, hy0_d, hcb_q, hcb_d, hcr_q, hcr_d;

  // Decode of the current cycle
  logic              is_emb, is_b8;
  logic [PH_W-1:0]   last_slot, slot;
  logic              open_evt, close_evt, line_live, take, blank, emit;
  logic [DATA_W-1:0] ny0, ny1, ncb, ncr;

  always_comb begin
    is_emb    = (eff_fmt == FMT_EMBED);
    is_b8     = (eff_fmt == FMT_BYTE8);
    last_slot = (is_emb || is_b8) ? LAST8 : LAST16;

    open_evt  = is_emb ? sav : hs_rise;
    close_evt = (is_emb && eav) || (fmt_switch && !open_evt);
    line_live = open_evt || (open_q && !close_evt);
    take      = line_live && !(is_emb && code_hit);
    slot      = (!is_emb && open_evt) ? SLOT_CB : phase_q;

    h_d = h_q;
    v_d = v_q;
    f_d = f_q;
    if (is_emb && code_hit) begin
      h_d = eav;
      v_d = st_vblank;
      f_d = st_field;
    end

    blank = is_emb ? v_d : ext_vsync;
    emit  = take && (slot == last_slot) && !blank;

    phase_d = phase_q;
    if (is_emb && sav)  phase_d = SLOT_CB;
    else if (take)      phase_d = (slot == last_slot) ? SLOT_CB : slot + 1'b1;

    hy0_d = hy0_q;
    hcb_d = hcb_q;
    hcr_d = hcr_q;
    if (take) begin
      if (!is_emb && !is_b8) begin
        if (slot == SLOT_CB) begin
          hy0_d = luma;
          hcb_d = chroma;
        end
      end else begin
        case (slot)
          SLOT_CB: hcb_d = luma;
          SLOT_Y0: hy0_d = luma;
          SLOT_CR: hcr_d = luma;
          default: ;
        endcase
      end
    end

    ny0 = hy0_q;
    ny1 = luma;
    ncb = hcb_q;
    ncr = (!is_emb && !is_b8) ? chroma : hcr_q;
  end

  // Sequencer state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SLOT_CB;
      open_q  <= 1'b0;
      h_q     <= 1'b0;
      v_q     <= 1'b0;
      f_q     <= 1'b0;
      hy0_q   <= '0;
      hcb_q   <= '0;
      hcr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      open_q  <= line_live;
      h_q     <= h_d;
      v_q     <= v_d;
      f_q     <= f_d;
      hy0_q   <= hy0_d;
      hcb_q   <= hcb_d;
      hcr_q   <= hcr_d;
    end
  end

  // Output pair, loaded only when a pair completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y0_o <= '0;
      y1_o <= '0;
      cb_o <= '0;
      cr_o <= '0;
    end else if (emit) begin
      y0_o <= ny0;
      y1_o <= ny1;
      cb_o <= ncb;
      cr_o <= ncr;
    end
  end

  // Output strobe and timing flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_valid_o <= 1'b0;
      hsync_o      <= 1'b0;
      vsync_o      <= 1'b0;
      field_o      <= 1'b0;
      active_o     <= 1'b0;
    end else begin
      pair_valid_o <= emit;
      hsync_o      <= is_emb ? h_d : ext_hsync;
      vsync_o      <= is_emb ? v_d : ext_vsync;
      field_o      <= is_emb && f_d;
      active_o     <= line_live && !blank;
    end
  end

endmodule

// File: rtl/ycc_unpack.sv
module ycc_unpack
  import ycc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_regs,
  input  logic              pin_narrow,
  input  logic              pin_embed,
  input  logic              reg_narrow,
  input  logic              reg_embed,
  input  logic              ext_hsync,
  input  logic              ext_vsync,
  input  logic [DATA_W-1:0] luma_in,
  input  logic [DATA_W-1:0] chroma_in,
  output logic [DATA_W-1:0] y0_o,
  output logic [DATA_W-1:0] y1_o,
  output logic [DATA_W-1:0] cb_o,
  output logic [DATA_W-1:0] cr_o,
  output logic              pair_valid_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              field_o,
  output logic              active_o
);

  logic rst_s1, rst_sync_n;
  logic hs_q, hs_rise, line_start;
  logic code_hit, sav, eav, st_vblank, st_field;
  logic fmt_switch;
  fmt_e fmt_q, eff_fmt;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hs_q <= 1'b0;
    else             hs_q <= ext_hsync;
  end

  assign hs_rise    = ext_hsync && !hs_q;
  assign line_start = hs_rise || sav;

  ycc_code_detect #(
    .DATA_W  (DATA_W),
    .PRE_LEN (3),
    .EOA_BIT (ST_EOA_BIT),
    .VB_BIT  (ST_VB_BIT),
    .FLD_BIT (ST_FLD_BIT)
  ) u_detect (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .din       (luma_in),
    .code_hit  (code_hit),
    .sav       (sav),
    .eav       (eav),
    .st_vblank (st_vblank),
    .st_field  (st_field)
  );

  ycc_fmt_ctrl u_fmt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .use_regs   (use_regs),
    .pin_embed  (pin_embed),
    .pin_narrow (pin_narrow),
    .reg_embed  (reg_embed),
    .reg_narrow (reg_narrow),
    .line_start (line_start),
    .fmt_q      (fmt_q),
    .eff_fmt    (eff_fmt),
    .fmt_switch (fmt_switch)
  );

  ycc_pair_asm #(
    .DATA_W (DATA_W)
  ) u_asm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .eff_fmt      (eff_fmt),
    .fmt_switch   (fmt_switch),
    .hs_rise      (hs_rise),
    .ext_hsync    (ext_hsync),
    .ext_vsync    (ext_vsync),
    .luma         (luma_in),
    .chroma       (chroma_in),
    .code_hit     (code_hit),
    .sav          (sav),
    .eav          (eav),
    .st_vblank    (st_vblank),
    .st_field     (st_field),
    .y0_o         (y0_o),
    .y1_o         (y1_o),
    .cb_o         (cb_o),
    .cr_o         (cr_o),
    .pair_valid_o (pair_valid_o),
    .hsync_o      (hsync_o),
    .vsync_o      (vsync_o),
    .field_o      (field_o),
    .active_o     (active_o)
  );

endmodule

// File: rtl/ycc_unpack_chk.sv
module ycc_unpack_chk
  import ycc_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pair_valid,
  input logic         active,
  input logic         field,
  input logic [W-1:0] pair_word,
  input logic         line_start,
  input logic         code_hit,
  input fmt_e         fmt_q,
  input fmt_e         eff_fmt
);

  // R3
  pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  // R3
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> $stable(pair_word));

  // R10
  pair_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> active);

  // R2
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(fmt_q));

  // R6
  code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_hit && eff_fmt == FMT_EMBED) |=> !pair_valid);

  // R8
  ext_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_fmt != FMT_EMBED) |=> !field);

endmodule

bind ycc_unpack ycc_unpack_chk #(.W(4*DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .pair_valid (pair_valid_o),
  .active     (active_o),
  .field      (field_o),
  .pair_word  ({y0_o, y1_o, cb_o, cr_o}),
  .line_start (line_start),
  .code_hit   (code_hit),
  .fmt_q      (fmt_q),
  .eff_fmt    (eff_fmt)
);

// File: tb/tb_ycc_unpack.sv
`timescale 1ns/1ps
module tb_ycc_unpack;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       use_regs, pin_narrow, pin_embed, reg_narrow, reg_embed;
  logic       ext_hsync, ext_vsync;
  logic [7:0] luma_in, chroma_in;
  logic [7:0] y0_o, y1_o, cb_o, cr_o;
  logic       pair_valid_o, hsync_o, vsync_o, field_o, active_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ycc_unpack dut (
    .clk(clk), .rst_n(rst_n), .use_regs(use_regs),
    .pin_narrow(pin_narrow), .pin_embed(pin_embed),
    .reg_narrow(reg_narrow), .reg_embed(reg_embed),
    .ext_hsync(ext_hsync), .ext_vsync(ext_vsync),
    .luma_in(luma_in), .chroma_in(chroma_in),
    .y0_o(y0_o), .y1_o(y1_o), .cb_o(cb_o), .cr_o(cr_o),
    .pair_valid_o(pair_valid_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .field_o(field_o), .active_o(active_o)
  );

  // {hs, vs, luma, chroma, exp_valid, exp {y0,y1,cb,cr}}
  localparam logic [50:0] VEC [19] = '{
    {1'b0, 1'b0, 8'h10, 8'h5A, 1'b0, 32'h0},
    {1'b1, 1'b0, 8'hA0, 8'h55, 1'b0, 32'h0},
    {1'b1, 1'b0, 8'hB1, 8'h66, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'hC2, 8'h77, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'hD3, 8'h88, 1'b1, 32'hB1D3A0C2},
    {1'b0, 1'b0, 8'h11, 8'h99, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'h22, 8'hAA, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'h33, 8'hBB, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'h44, 8'hCC, 1'b1, 32'h22441133},
    {1'b0, 1'b1, 8'h55, 8'h00, 1'b0, 32'h0},
    {1'b0, 1'b1, 8'h66, 8'h00, 1'b0, 32'h0},
    {1'b0, 1'b1, 8'h77, 8'h00, 1'b0, 32'h0},
    {1'b0, 1'b1, 8'h88, 8'h00, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'h01, 8'h12, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'h02, 8'h34, 1'b0, 32'h0},
    {1'b1, 1'b0, 8'hA5, 8'h56, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'hA6, 8'h78, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'hA7, 8'h9A, 1'b0, 32'h0},
    {1'b0, 1'b0, 8'hA8, 8'hBC, 1'b1, 32'hA6A8A5A7}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic hs, input logic vs, input logic [7:0] l, input logic [7:0] c);
    ext_hsync = hs;
    ext_vsync = vs;
    luma_in   = l;
    chroma_in = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_code(input logic [7:0] status);
    step(1'b0, 1'b0, 8'hFF, 8'h3C);
    chk("R6 preamble byte no pair", pair_valid_o, 1'b0);
    step(1'b0, 1'b0, 8'h00, 8'h3C);
    chk("R6 preamble byte no pair", pair_valid_o, 1'b0);
    step(1'b0, 1'b0, 8'h00, 8'h3C);
    chk("R6 preamble byte no pair", pair_valid_o, 1'b0);
    step(1'b0, 1'b0, status, 8'h3C);
    chk("R6 status byte no pair", pair_valid_o, 1'b0);
  endtask

  task automatic chk_all_zero(input string tag);
    chk(tag, {y0_o, y1_o, cb_o, cr_o}, 32'h0);
    chk(tag, {pair_valid_o, hsync_o, vsync_o, field_o, active_o}, 5'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    use_regs = 1'b0; pin_narrow = 1'b1; pin_embed = 1'b0;
    reg_narrow = 1'b0; reg_embed = 1'b0;
    ext_hsync = 1'b0; ext_vsync = 1'b0; luma_in = '0; chroma_in = '0;
    repeat (3) @(negedge clk);
    chk_all_zero("R9 outputs in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all_zero("R9 outputs after reset");

    // Narrow mode from pins, external sync (table)
    for (int i = 0; i < 19; i++) begin
      step(VEC[i][50], VEC[i][49], VEC[i][48:41], VEC[i][40:33]);
      chk($sformatf("R4 R9 vec %0d valid", i), pair_valid_o, VEC[i][32]);
      if (VEC[i][32])
        chk($sformatf("R4 R5 vec %0d pair", i), {y0_o, y1_o, cb_o, cr_o}, VEC[i][31:0]);
      if (i == 9)  chk("R8 vsync follows input", vsync_o, 1'b1);
      if (i == 10) chk("R10 active low in vblank", active_o, 1'b0);
      if (i == 1)  chk("R8 hsync follows input", hsync_o, 1'b1);
    end

    // Wide mode from registers while pins still ask for narrow (R1)
    use_regs = 1'b1; reg_narrow = 1'b0; reg_embed = 1'b0;
    step(1'b0, 1'b0, 8'h5E, 8'h5F);
    chk("R2 no change without line start", pair_valid_o, 1'b0);
    step(1'b1, 1'b0, 8'h10, 8'h20);
    chk("R1 R3 first sample no pair", pair_valid_o, 1'b0);
    chk("R8 hsync follows input", hsync_o, 1'b1);
    chk("R8 field low outside embedded", field_o, 1'b0);
    step(1'b0, 1'b0, 8'h11, 8'h21);
    chk("R1 R3 wide pair valid", pair_valid_o, 1'b1);
    chk("R3 wide pair", {y0_o, y1_o, cb_o, cr_o}, 32'h10112021);
    step(1'b0, 1'b0, 8'h12, 8'h22);
    chk("R3 hold between pairs", {pair_valid_o, y0_o}, {1'b0, 8'h10});
    step(1'b0, 1'b0, 8'h13, 8'h23);
    chk("R3 wide pair", {pair_valid_o, y0_o, y1_o, cb_o, cr_o}, {1'b1, 32'h12132223});

    // Request narrow mid-line: wide continues until the line start (R2)
    reg_narrow = 1'b1;
    step(1'b0, 1'b0, 8'h30, 8'h40);
    chk("R2 still wide", pair_valid_o, 1'b0);
    step(1'b0, 1'b0, 8'h31, 8'h41);
    chk("R2 still wide pair", {pair_valid_o, y0_o, y1_o, cb_o, cr_o}, {1'b1, 32'h30314041});
    step(1'b1, 1'b0, 8'hA0, 8'hE1);
    chk("R2 narrow after line start", pair_valid_o, 1'b0);
    step(1'b0, 1'b0, 8'hA1, 8'hE2);
    chk("R2 no pair after two bytes", pair_valid_o, 1'b0);
    step(1'b0, 1'b0, 8'hA2, 8'hE3);
    chk("R4 no pair", pair_valid_o, 1'b0);
    step(1'b0, 1'b0, 8'hA3, 8'hE4);
    chk("R4 R5 narrow pair", {pair_valid_o, y0_o, y1_o, cb_o, cr_o}, {1'b1, 32'hA1A3A0A2});

    // Embedded mode from registers, embed bit overrides narrow bit (R1)
    reg_embed = 1'b1;
    send_code(8'h80);
    chk("R7 SAV flags", {hsync_o, vsync_o, field_o, active_o}, 4'b0001);
    step(1'b0, 1'b0, 8'h40, 8'h01);
    step(1'b1, 1'b0, 8'h50, 8'h02);
    chk("R8 ext hsync ignored in embedded", hsync_o, 1'b0);
    step(1'b0, 1'b0, 8'h60, 8'h03);
    step(1'b0, 1'b1, 8'h70, 8'h04);
    chk("R6 R1 embedded pair", {pair_valid_o, y0_o, y1_o, cb_o, cr_o}, {1'b1, 32'h50704060});
    chk("R8 ext vsync ignored in embedded", vsync_o, 1'b0);
    send_code(8'h90);
    chk("R7 EAV flags", {hsync_o, vsync_o, field_o, active_o}, 4'b1000);
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0, 8'(8'h10 * (k + 1)), 8'h05);
      chk("R6 closed line no pair", pair_valid_o, 1'b0);
    end
    send_code(8'hE0);
    chk("R7 blanking SAV flags", {hsync_o, vsync_o, field_o, active_o}, 4'b0110);
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0, 8'(8'h21 + k), 8'h06);
      chk("R7 no pair in vertical blanking", pair_valid_o, 1'b0);
    end
    send_code(8'hC0);
    chk("R7 field SAV flags", {hsync_o, vsync_o, field_o, active_o}, 4'b0011);
    step(1'b0, 1'b0, 8'h41, 8'h07);
    step(1'b0, 1'b0, 8'h42, 8'h08);
    step(1'b0, 1'b0, 8'h43, 8'h09);
    step(1'b0, 1'b0, 8'h44, 8'h0A);
    chk("R6 R10 field pair", {pair_valid_o, active_o, y0_o, y1_o, cb_o, cr_o}, {2'b11, 32'h42444143});

    // Reset in mid-run, then embedded mode chosen by pins
    rst_n = 1'b0;
    @(negedge clk);
    chk_all_zero("R9 outputs in second reset");
    use_regs = 1'b0; pin_embed = 1'b1; pin_narrow = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0, 8'(8'h11 + k), 8'h0B);
      chk("R9 no pair before line start", {pair_valid_o, active_o}, 2'b00);
    end
    send_code(8'h80);
    step(1'b0, 1'b0, 8'h61, 8'h0C);
    step(1'b0, 1'b0, 8'h62, 8'h0D);
    step(1'b0, 1'b0, 8'h63, 8'h0E);
    step(1'b0, 1'b0, 8'h64, 8'h0F);
    chk("R1 pins embedded pair", {pair_valid_o, y0_o, y1_o, cb_o, cr_o}, {1'b1, 32'h62646163});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule